// File: doc/BRIEF.md
# Four-Channel DAC Simultaneous Update Register

This block holds the host-side register logic for four 12-bit converter channels. The host builds each channel's next code in two byte writes. The first write places the lower eight bits in a shared holding byte. The second write supplies the upper four bits and names the target channel. Together they form a staged code and mark that channel as pending. The converter outputs do not move while codes are being staged.

A read access to any one of the four channel addresses is the commit. On that access every pending channel copies its staged code into its output latch, and all channels move in the same clock cycle. A channel that was not restaged keeps its present output. The block then clears all pending marks and raises a one-cycle load strobe toward the converter. The bus cycle itself returns no data: the block only uses the read as a trigger.

Top module: `dacu_sync_update`

## Requirements
- R1: After a synchronous reset, every output latch holds midscale code 2048 (0x800), no channel is pending, and `dac_load` is low. A reset also discards any pending staged data.
- R2: A write at offset 0 stores `host_wdata[7:0]` as the low byte of the next staged code, with bit 0 as the code's least significant bit. This byte is kept until the next write at offset 0, so several high-byte writes can reuse it.
- R3: A write at offset 1 forms a staged code for the channel named in `host_wdata[7:6]`. Code bits 11:8 come from `host_wdata[3:0]` and code bits 7:0 come from the held low byte. Bits 5:4 are ignored. The write marks that channel as pending.
- R4: Writes never change `dac_codes` or `dac_load`. Writes at any offset other than 0 and 1 are ignored.
- R5: A read at any of offsets 4, 5, 6 or 7 loads every pending channel's staged code into its output latch at the same clock edge. The new codes appear on `dac_codes` after that edge. Channel n occupies bits [12n+11:12n].
- R6: On an update, a channel that is not pending keeps its present output code.
- R7: An update clears every pending mark. A second update read with no new staging leaves all outputs unchanged.
- R8: `dac_load` is high for exactly one cycle after each update read. Reads at offsets 0 to 3 cause neither an update nor a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 3 | Register offset of the access |
| host_wdata | input | 8 | Write data byte |
| host_wr | input | 1 | Write access strobe, one cycle per access |
| host_rd | input | 1 | Read access strobe, one cycle per access |
| dac_codes | output | 48 | Four latched 12-bit codes, channel 0 in the low bits |
| dac_load | output | 1 | One-cycle load pulse to the converter after an update |

## Verification
The hardest situation to reach is an update in which pending and non-pending channels are mixed. It must be shown that one commit moves only the restaged channels and leaves the others holding codes from an earlier commit. The stimulus first commits one channel, then restages two different channels, and commits through a different channel address. A later commit is preceded by a write to an unused offset, and a reused low byte shows that the held byte survives between high-byte writes. A reset placed between staging and commit shows that the pending marks are discarded.

// File: rtl/dacu_pkg.sv
package dacu_pkg;

    // Register offsets; the commit window is CH_BASE .. CH_BASE+channels-1
    localparam int OFS_LO  = 0;
    localparam int OFS_HI  = 1;
    localparam int CH_BASE = 4;

    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
        logic upd;
    } acc_t;

endpackage

// File: rtl/dacu_host_decode.sv
module dacu_host_decode
    import dacu_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int NCH    = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output acc_t              acc_o
);

    localparam int CH_TOP = CH_BASE + NCH;

    logic in_window;

    always_comb begin
        in_window   = (int'(addr_i) >= CH_BASE) && (int'(addr_i) < CH_TOP);
        acc_o.wr_lo = wr_i && (int'(addr_i) == OFS_LO);
        acc_o.wr_hi = wr_i && (int'(addr_i) == OFS_HI);
        acc_o.upd   = rd_i && in_window;
    end

endmodule

// File: rtl/dacu_stage.sv
module dacu_stage #(
    parameter int NCH    = 4,
    parameter int CODE_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_lo_i,
    input  logic                         wr_hi_i,
    input  logic                         upd_i,
    input  logic [BYTE_W-1:0]            wdata_i,
    output logic [NCH-1:0][CODE_W-1:0]   stage_o,
    output logic [NCH-1:0]               pend_o
);

    localparam int HI_W = CODE_W - BYTE_W;
    localparam int CH_W = $clog2(NCH);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0]          lo;
        logic [NCH-1:0][CODE_W-1:0] stage;
        logic [NCH-1:0]             pend;
    } st_t;

    st_t             s_d, s_q;
    logic [CH_W-1:0] ch;
    logic            unused_mid_bits;

    assign ch              = wdata_i[BYTE_W-1 -: CH_W];
    assign unused_mid_bits = ^wdata_i[BYTE_W-CH_W-1:HI_W];

    always_comb begin
        s_d = s_q;
        if (wr_lo_i) begin
            s_d.lo = wdata_i;
        end
        if (upd_i) begin
            s_d.pend = '0;
        end
        if (wr_hi_i) begin
            s_d.stage[ch] = {wdata_i[HI_W-1:0], s_q.lo};
            s_d.pend[ch]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.lo    <= '0;
            s_q.stage <= {NCH{MID}};
            s_q.pend  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stage_o = s_q.stage;
    assign pend_o  = s_q.pend;

    // R3: a completed high byte leaves its channel pending
    a_r3_hi_marks_pending: assert property (@(posedge clk) disable iff (rst)
        wr_hi_i |=> pend_o[$past(ch)]);

    // R7: an update with no simultaneous staging leaves nothing pending
    a_r7_update_clears: assert property (@(posedge clk) disable iff (rst)
        (upd_i && !wr_hi_i) |=> (pend_o == '0));

    // R2: the held low byte changes only on a low-byte write
    a_r2_low_byte_held: assert property (@(posedge clk) disable iff (rst)
        !wr_lo_i |=> $stable(s_q.lo));

    // R1: pending marks are clear right after reset
    a_r1_reset_no_pending: assert property (@(posedge clk)
        $past(rst) |-> (pend_o == '0));

endmodule

// File: rtl/dacu_out_latch.sv
module dacu_out_latch #(
    parameter int NCH    = 4,
    parameter int CODE_W = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       upd_i,
    input  logic [NCH-1:0]             pend_i,
    input  logic [NCH-1:0][CODE_W-1:0] stage_i,
    output logic [NCH-1:0][CODE_W-1:0] code_o,
    output logic                       load_o
);

    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    typedef struct packed {
        logic [NCH-1:0][CODE_W-1:0] code;
        logic                       load;
    } ol_t;

    ol_t o_d, o_q;

    always_comb begin
        o_d      = o_q;
        o_d.load = upd_i;
        for (int c = 0; c < NCH; c++) begin
            if (upd_i && pend_i[c]) begin
                o_d.code[c] = stage_i[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q.code <= {NCH{MID}};
            o_q.load <= 1'b0;
        end else begin
            o_q <= o_d;
        end
    end

    assign code_o = o_q.code;
    assign load_o = o_q.load;

    // R8: the strobe is raised only in the cycle after an update read
    a_r8_load_only_after_update: assert property (@(posedge clk) disable iff (rst)
        load_o |-> $past(upd_i));

    // R8: every update read produces the strobe
    a_r8_update_gives_load: assert property (@(posedge clk) disable iff (rst)
        upd_i |=> load_o);

    // R1: midscale on every channel right after reset
    a_r1_reset_midscale: assert property (@(posedge clk)
        $past(rst) |-> (code_o == {NCH{MID}}));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R6: no update or not pending -> the channel holds
        a_r6_channel_holds: assert property (@(posedge clk) disable iff (rst)
            (!upd_i || !pend_i[g]) |=> $stable(code_o[g]));

        // R5: a pending channel takes its staged code on the update
        a_r5_channel_loads: assert property (@(posedge clk) disable iff (rst)
            (upd_i && pend_i[g]) |=> (code_o[g] == $past(stage_i[g])));
    end

endmodule

// File: rtl/dacu_sync_update.sv
module dacu_sync_update
    import dacu_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CODE_W = 12,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       host_addr,
    input  logic [BYTE_W-1:0]       host_wdata,
    input  logic                    host_wr,
    input  logic                    host_rd,
    output logic [NCH*CODE_W-1:0]   dac_codes,
    output logic                    dac_load
);

    acc_t                       acc;
    logic [NCH-1:0][CODE_W-1:0] stage;
    logic [NCH-1:0]             pend;
    logic [NCH-1:0][CODE_W-1:0] code;

    dacu_host_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) i_decode (
        .addr_i (host_addr),
        .wr_i   (host_wr),
        .rd_i   (host_rd),
        .acc_o  (acc)
    );

    dacu_stage #(.NCH(NCH), .CODE_W(CODE_W), .BYTE_W(BYTE_W)) i_stage (
        .clk     (clk),
        .rst     (rst),
        .wr_lo_i (acc.wr_lo),
        .wr_hi_i (acc.wr_hi),
        .upd_i   (acc.upd),
        .wdata_i (host_wdata),
        .stage_o (stage),
        .pend_o  (pend)
    );

    dacu_out_latch #(.NCH(NCH), .CODE_W(CODE_W)) i_latch (
        .clk     (clk),
        .rst     (rst),
        .upd_i   (acc.upd),
        .pend_i  (pend),
        .stage_i (stage),
        .code_o  (code),
        .load_o  (dac_load)
    );

    assign dac_codes = code;

    // R4: a write with no read never moves the outputs
    a_r4_write_no_output_change: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_rd) |=> ($stable(dac_codes) && !dac_load));

endmodule

// File: tb/test_dacu_sync_update.sv
module test_dacu_sync_update;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  host_addr;
    logic [7:0]  host_wdata;
    logic        host_wr;
    logic        host_rd;
    logic [47:0] dac_codes;
    logic        dac_load;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    dacu_sync_update i_dacu_sync_update (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .dac_codes  (dac_codes),
        .dac_load   (dac_load)
    );

    // op: 0 idle, 1 write, 2 read
    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  addr;
        logic [7:0]  data;
        logic [47:0] exp;
        logic        stb;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [0:NV-1] = '{
        '{2'd1, 3'd0, 8'h34, 48'h800800800800, 1'b0, 4'd2}, // R2 low byte
        '{2'd1, 3'd1, 8'h42, 48'h800800800800, 1'b0, 4'd4}, // R4 ch1 staged, no move
        '{2'd2, 3'd4, 8'h00, 48'h800800234800, 1'b1, 4'd5}, // R5 commit via offset 4
        '{2'd1, 3'd0, 8'hFF, 48'h800800234800, 1'b0, 4'd4},
        '{2'd1, 3'd1, 8'h0F, 48'h800800234800, 1'b0, 4'd4}, // ch0 = 0xFFF
        '{2'd1, 3'd0, 8'h00, 48'h800800234800, 1'b0, 4'd4},
        '{2'd1, 3'd1, 8'hC0, 48'h800800234800, 1'b0, 4'd4}, // ch3 = 0x000
        '{2'd2, 3'd7, 8'h00, 48'h000800234FFF, 1'b1, 4'd5}, // R5 two channels together
        '{2'd2, 3'd5, 8'h00, 48'h000800234FFF, 1'b1, 4'd7}, // R7 nothing pending
        '{2'd2, 3'd2, 8'h00, 48'h000800234FFF, 1'b0, 4'd8}, // R8 read outside window
        '{2'd1, 3'd0, 8'h5A, 48'h000800234FFF, 1'b0, 4'd4},
        '{2'd1, 3'd1, 8'h81, 48'h000800234FFF, 1'b0, 4'd3}, // R3 ch2 = 0x15A
        '{2'd1, 3'd3, 8'hC7, 48'h000800234FFF, 1'b0, 4'd4}, // R4 unused offset
        '{2'd2, 3'd6, 8'h00, 48'h00015A234FFF, 1'b1, 4'd6}, // R6 only ch2 moves
        '{2'd1, 3'd0, 8'h11, 48'h00015A234FFF, 1'b0, 4'd4},
        '{2'd1, 3'd1, 8'h79, 48'h00015A234FFF, 1'b0, 4'd3}, // R3 bits 5:4 ignored
        '{2'd1, 3'd1, 8'h03, 48'h00015A234FFF, 1'b0, 4'd2}, // R2 low byte reused
        '{2'd2, 3'd4, 8'h00, 48'h00015A911311, 1'b1, 4'd3}
    };

    task automatic check(input string req, input string what,
                         input logic [47:0] got, input logic [47:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // drive one access for one cycle; returns after the capturing edge
    task automatic access(input logic [1:0] op, input logic [2:0] a, input logic [7:0] d);
        host_addr  = a;
        host_wdata = d;
        host_wr    = (op == 2'd1);
        host_rd    = (op == 2'd2);
        @(negedge clk);
        host_wr    = 1'b0;
        host_rd    = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        host_addr = '0; host_wdata = '0; host_wr = 1'b0; host_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        check("R1", "reset codes", dac_codes, 48'h800800800800);
        check("R1", "reset strobe", {47'd0, dac_load}, 48'd0);

        for (int i = 0; i < NV; i++) begin
            access(TBL[i].op, TBL[i].addr, TBL[i].data);
            check($sformatf("R%0d", TBL[i].req), $sformatf("vector %0d codes", i),
                  dac_codes, TBL[i].exp);
            check($sformatf("R%0d", TBL[i].req), $sformatf("vector %0d strobe", i),
                  {47'd0, dac_load}, {47'd0, TBL[i].stb});
        end

        // R8: strobe lasts a single cycle
        access(2'd0, 3'd0, 8'h00);
        check("R8", "strobe drops", {47'd0, dac_load}, 48'd0);

        // R1: reset between staging and commit discards the pending code
        access(2'd1, 3'd0, 8'h77);
        access(2'd1, 3'd1, 8'h85);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "midscale after reset", dac_codes, 48'h800800800800);
        access(2'd2, 3'd5, 8'h00);
        check("R1", "no pending after reset", dac_codes, 48'h800800800800);
        check("R8", "strobe on empty commit", {47'd0, dac_load}, 48'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule